// File: doc/BRIEF.md
# Decimal Adjust Accumulator Unit

This unit repairs an 8-bit accumulator value after a packed-decimal addition or subtraction has been done in plain binary. It takes the raw accumulator together with the carry, half-carry and subtract indications that the binary operation left behind. It works out which decimal digits overflowed and adds a correction constant. It then produces the corrected accumulator and a complete set of condition flags for it.

A one-cycle `start_i` strobe captures the inputs. One clock later the unit raises `valid_o` for one cycle. The corrected value and the flags stay on the outputs until the next strobe. The datapath between the input pins and the output register is purely combinational.

Top module: `bcd_fixup_unit`

## Requirements
- R1: A low-digit correction is selected when acc_i[3:0] is greater than 9 or hc_i is 1.
- R2: A high-digit correction is selected when acc_i is greater than 0x99 or cy_i is 1. When it is selected, cy_o is 1. Otherwise cy_o equals cy_i.
- R3: With sub_i = 0, the corrected value is acc_i + 0x06 for a low-only correction, + 0x60 for a high-only correction, + 0x66 for both corrections, and acc_i unchanged for neither (all modulo 256).
- R4: With sub_i = 1, the three correction cases add 0xFA, 0xA0 and 0x9A respectively (modulo 256), and the no-correction case leaves acc_i unchanged.
- R5: The half-carry output hc_o is taken from the unadjusted acc_i as follows:
  - sub_i = 0: hc_o = (acc_i[3:0] >= 0xA).
  - sub_i = 1 and hc_i = 1: hc_o = (acc_i[3:0] < 6).
  - sub_i = 1 and hc_i = 0: hc_o = 0.
- R6: sign_o is bit 7 of the result and zero_o is 1 when the result is 0x00. par_o is 1 when the result holds an even number of one bits.
- R7: bit3_o and bit5_o copy result bits 3 and 5.
- R8: sub_o equals the sub_i value captured with the strobe.
- R9: valid_o is high exactly in the cycle after each start_i cycle. Without a strobe, all result outputs hold their values.
- R10: While rst_n is low, valid_o and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture strobe for one adjustment |
| acc_i | input | 8 | Accumulator value before adjustment |
| cy_i | input | 1 | Incoming carry |
| hc_i | input | 1 | Incoming half-carry |
| sub_i | input | 1 | 1 after a subtraction, 0 after an addition |
| acc_o | output | 8 | Adjusted accumulator |
| sign_o | output | 1 | Result bit 7 |
| zero_o | output | 1 | Result is zero |
| hc_o | output | 1 | New half-carry |
| par_o | output | 1 | Even parity of result |
| cy_o | output | 1 | New carry |
| sub_o | output | 1 | Subtract flag passed through |
| bit3_o | output | 1 | Result bit 3 |
| bit5_o | output | 1 | Result bit 5 |
| valid_o | output | 1 | Result updated this cycle |

## Verification
The bench drives every combination of accumulator value, carry, half-carry and mode, so each boundary is covered:
- Digit 9 against 0xA, and 0x99 against 0x9A: a design that used >= in place of > would correct 0x09 or 0x99 that needs no fix.
- The subtract-mode half-carry with its nibble-6 threshold: mixing up the three rules would leave hc_o wrong there.
- Inputs such as 0x9A that wrap to zero: a wrong carry or zero flag shows up on exactly these values.
- Back-to-back strobes and idle gaps with the inputs changed: a broken capture enable would either drop a result or let acc_o drift.

// File: rtl/bcd_fixup_pkg.sv
package bcd_fixup_pkg;
    localparam int DW        = 8;
    localparam int NW        = DW / 2;
    localparam int DIGIT_MAX = 9;
    localparam logic [DW-1:0] BYTE_MAX = 8'h99;
    localparam logic [DW-1:0] FIX_LO   = 8'h06;
    localparam logic [DW-1:0] FIX_HI   = FIX_LO << NW;
    localparam logic [DW-1:0] FIX_BOTH = FIX_LO + FIX_HI;
    localparam logic [DW-1:0] SUB_LO   = 8'h00 - FIX_LO;
    localparam logic [DW-1:0] SUB_HI   = 8'h00 - FIX_HI;
    localparam logic [DW-1:0] SUB_BOTH = 8'h00 - FIX_BOTH;
    localparam logic [NW-1:0] HC_ADD_THR = 4'hA;
    localparam logic [NW-1:0] HC_SUB_THR = 4'h6;

    typedef struct packed {
        logic sign;
        logic zero;
        logic half;
        logic parity;
        logic carry;
        logic sub;
        logic bit3;
        logic bit5;
    } flag_t;

    typedef struct packed {
        logic [DW-1:0] acc;
        flag_t         flg;
        logic          vld;
    } state_t;
endpackage

// File: rtl/bcd_fixup_decide.sv
module bcd_fixup_decide
    import bcd_fixup_pkg::*;
(
    input  logic [DW-1:0] acc,
    input  logic          cy,
    input  logic          hc,
    input  logic          sub,
    output logic [DW-1:0] offset,
    output logic          hc_next,
    output logic          cy_next
);
    logic lo_fix;
    logic hi_fix;

    always_comb begin
        lo_fix = (int'(acc[NW-1:0]) > DIGIT_MAX) || hc;
        hi_fix = (acc > BYTE_MAX) || cy;
        unique case ({hi_fix, lo_fix})
            2'b01:   offset = sub ? SUB_LO   : FIX_LO;
            2'b10:   offset = sub ? SUB_HI   : FIX_HI;
            2'b11:   offset = sub ? SUB_BOTH : FIX_BOTH;
            default: offset = '0;
        endcase
        cy_next = hi_fix ? 1'b1 : cy;
        if (!sub) begin
            hc_next = (acc[NW-1:0] >= HC_ADD_THR);
        end else if (hc) begin
            hc_next = (acc[NW-1:0] < HC_SUB_THR);
        end else begin
            hc_next = 1'b0;
        end
    end
endmodule

// File: rtl/bcd_fixup_flags.sv
module bcd_fixup_flags
    import bcd_fixup_pkg::*;
(
    input  logic [DW-1:0] res,
    input  logic          hc_next,
    input  logic          cy_next,
    input  logic          sub,
    output flag_t         flg
);
    always_comb begin
        flg.sign   = res[DW-1];
        flg.zero   = (res == '0);
        flg.half   = hc_next;
        flg.parity = ~^res;
        flg.carry  = cy_next;
        flg.sub    = sub;
        flg.bit3   = res[3];
        flg.bit5   = res[5];
    end
endmodule

// File: rtl/bcd_fixup_unit.sv
module bcd_fixup_unit
    import bcd_fixup_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] acc_i,
    input  logic          cy_i,
    input  logic          hc_i,
    input  logic          sub_i,
    output logic [DW-1:0] acc_o,
    output logic          sign_o,
    output logic          zero_o,
    output logic          hc_o,
    output logic          par_o,
    output logic          cy_o,
    output logic          sub_o,
    output logic          bit3_o,
    output logic          bit5_o,
    output logic          valid_o
);
    logic [DW-1:0] offset;
    logic [DW-1:0] sum;
    logic          hc_next;
    logic          cy_next;
    flag_t         flg_new;
    state_t        st_d;
    state_t        st_q;

    bcd_fixup_decide u_decide (
        .acc     (acc_i),
        .cy      (cy_i),
        .hc      (hc_i),
        .sub     (sub_i),
        .offset  (offset),
        .hc_next (hc_next),
        .cy_next (cy_next)
    );

    assign sum = acc_i + offset;

    bcd_fixup_flags u_flags (
        .res     (sum),
        .hc_next (hc_next),
        .cy_next (cy_next),
        .sub     (sub_i),
        .flg     (flg_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = start_i;
        if (start_i) begin
            st_d.acc = sum;
            st_d.flg = flg_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o   = st_q.acc;
    assign sign_o  = st_q.flg.sign;
    assign zero_o  = st_q.flg.zero;
    assign hc_o    = st_q.flg.half;
    assign par_o   = st_q.flg.parity;
    assign cy_o    = st_q.flg.carry;
    assign sub_o   = st_q.flg.sub;
    assign bit3_o  = st_q.flg.bit3;
    assign bit5_o  = st_q.flg.bit5;
    assign valid_o = st_q.vld;
endmodule

// File: rtl/bcd_fixup_chk.sv
module bcd_fixup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [7:0] acc_i,
    input logic       cy_i,
    input logic       hc_i,
    input logic       sub_i,
    input logic [7:0] acc_o,
    input logic       hc_o,
    input logic       cy_o,
    input logic       sub_o,
    input logic       valid_o
);
    // R9
    valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!valid_o && $stable(acc_o) && $stable(cy_o) && $stable(hc_o)));
    // R2
    carry_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cy_i) |=> cy_o);
    // R8
    sub_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sub_o == $past(sub_i)));
    // R5
    half_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sub_i && !hc_i) |=> !hc_o);
    // R3
    no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !hc_i && !cy_i && acc_i[3:0] <= 4'd9 && acc_i <= 8'h99)
        |=> (acc_o == $past(acc_i)));
endmodule

bind bcd_fixup_unit bcd_fixup_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .acc_i   (acc_i),
    .cy_i    (cy_i),
    .hc_i    (hc_i),
    .sub_i   (sub_i),
    .acc_o   (acc_o),
    .hc_o    (hc_o),
    .cy_o    (cy_o),
    .sub_o   (sub_o),
    .valid_o (valid_o)
);

// File: tb/bcd_fixup_unit_tb.sv
module bcd_fixup_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] acc_i = '0;
    logic       cy_i = 1'b0, hc_i = 1'b0, sub_i = 1'b0;
    logic [7:0] acc_o;
    logic       sign_o, zero_o, hc_o, par_o, cy_o, sub_o, bit3_o, bit5_o, valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    bcd_fixup_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .acc_i(acc_i),
        .cy_i(cy_i), .hc_i(hc_i), .sub_i(sub_i), .acc_o(acc_o),
        .sign_o(sign_o), .zero_o(zero_o), .hc_o(hc_o), .par_o(par_o),
        .cy_o(cy_o), .sub_o(sub_o), .bit3_o(bit3_o), .bit5_o(bit5_o),
        .valid_o(valid_o)
    );

    function automatic logic [15:0] model(input logic [7:0] a, input logic c,
                                          input logic h, input logic n);
        logic [7:0] r;
        logic lo, hi, nh, nc;
        int ones;
        lo = (a[3:0] > 4'd9) || h;
        hi = (a > 8'h99) || c;
        r  = a;
        if (lo && hi)  r = a + (n ? 8'h9A : 8'h66);
        else if (lo)   r = a + (n ? 8'hFA : 8'h06);
        else if (hi)   r = a + (n ? 8'hA0 : 8'h60);
        nc = hi ? 1'b1 : c;
        if (!n)     nh = (a[3:0] >= 4'hA);
        else if (h) nh = (a[3:0] < 4'h6);
        else        nh = 1'b0;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += r[i];
        return {r, r[7], (r == 8'h00), nh, (ones % 2 == 0), nc, n, r[3], r[5]};
    endfunction

    function automatic logic [15:0] observed();
        return {acc_o, sign_o, zero_o, hc_o, par_o, cy_o, sub_o, bit3_o, bit5_o};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] a, input logic c, input logic h,
                         input logic n, input string tag);
        @(negedge clk);
        acc_i = a; cy_i = c; hc_i = h; sub_i = n; start_i = 1'b1;
        exp_q.push_back(model(a, c, h, n));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected valid", observed(), 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(observed() == e, t, observed(), e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R10 reset state
        check({observed(), valid_o} == 17'h0, "R10 reset", observed(), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o == 1'b0, "R9 no valid without strobe", {15'h0, valid_o}, 16'h0);

        // directed boundaries
        drive(8'h09, 0, 0, 0, "R1 digit 9 no fix");
        drive(8'h0A, 0, 0, 0, "R1 digit A fix");
        drive(8'h12, 0, 1, 0, "R1 hc forces low fix");
        drive(8'h99, 0, 0, 0, "R2 0x99 no high fix");
        drive(8'h9A, 0, 0, 0, "R2 0x9A wraps to zero");
        drive(8'h25, 1, 0, 0, "R2 carry forces high fix");
        drive(8'h3C, 0, 0, 0, "R3 add low only");
        drive(8'hA3, 0, 0, 0, "R3 add high only");
        drive(8'h0F, 0, 1, 1, "R4 sub low only");
        drive(8'hF5, 1, 0, 1, "R4 sub high only");
        drive(8'hFF, 1, 1, 1, "R4 sub both");
        drive(8'h15, 0, 1, 1, "R5 sub hc nibble below 6");
        drive(8'h16, 0, 1, 1, "R5 sub hc nibble 6");
        drive(8'h1E, 0, 0, 1, "R5 sub no hc clears");
        drive(8'h80, 0, 0, 0, "R6 sign and parity");
        drive(8'h28, 0, 0, 0, "R7 bits 3 and 5");
        drive(8'h44, 0, 0, 1, "R8 sub passes");
        idle();

        // R9 hold: change inputs with no strobe
        @(negedge clk);
        held = observed();
        acc_i = 8'h5B; cy_i = 1'b1; hc_i = 1'b1; sub_i = 1'b0;
        repeat (3) @(negedge clk);
        check(observed() == held, "R9 hold without strobe", observed(), held);
        check(valid_o == 1'b0, "R9 valid low when idle", {15'h0, valid_o}, 16'h0);

        // exhaustive sweep, back-to-back strobes
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 256; a++) begin
                drive(a[7:0], m[0], m[1], m[2], "R1 R2 R3 R4 R5 R6 R7 R8 sweep");
            end
            idle();
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results returned",
              16'(exp_q.size()), 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule